// File: doc/BRIEF.md
# Single-Wire Slave Command and Scratchpad Controller

This block is the byte-level brain of a single-wire slave sensor. A bit-layer front end, not part of this block, recovers bus resets, bytes written by the master and read-slot requests. It hands them over as a reset strobe, a valid/ready byte channel and a one-cycle slot request. The controller answers every read slot one cycle later with the bit the device would leave on the wire.

Each transaction starts with a bus reset. An addressing command follows: the master can read the 64-bit identity, select this device by sending that identity, or address all devices at once. A function command comes last. The function commands start a temperature conversion, write or read the nine-byte scratchpad, copy the three user bytes into a nonvolatile shadow or recall them from it, and report the power mode. Long operations are timed by parameterised cycle counts. While one of them runs, read slots report its progress.

Top module: `ow_cmd_ctrl`

## Requirements
- R1: After the asynchronous reset the scratchpad reads temperature 0550h, the parameterised alarm-high byte, alarm-low byte and configuration, and the fixed bytes FFh, 0Ch and 10h. The shadow holds the same three parameter values.
- R2: Only the order bus reset, addressing byte, function byte is obeyed. An unknown or misplaced byte makes the device ignore all bytes and return 1 on every slot until the next bus reset. A bus reset in the same cycle as a byte wins, and the byte is dropped.
- R3: Addressing code 33h makes the next 64 slots return the identity LSB first: family byte 28h, the 48-bit serial number, then the check byte. A function command is then accepted.
- R4: Addressing code 55h takes 8 bytes compared with the identity, lowest byte first. An exact match enables a function command; any mismatch behaves as in R2.
- R5: Addressing code CCh goes straight to the function command.
- R6: Check bytes use x^8+x^5+x^4+1, start at 0 and take data LSB first. Scratchpad byte 8 covers bytes 0 to 7, and the identity top byte covers its low 7 bytes.
- R7: Function 4Eh stores three bytes into bytes 2, 3 and 4 in that order. Byte 4 keeps only bits 6:5 and reads bit 7 as 0 and bits 4:0 as 1. A bus reset before the third byte keeps the bytes already stored.
- R8: Function BEh returns bytes 0 to 8 over 72 slots, LSB first. Later slots return 1, and a bus reset ends the read early.
- R9: Function 48h keeps rx_ready_o low for COPY_CYCLES cycles, then writes bytes 2 to 4 into the shadow. Slots return 0 while it runs and 1 afterwards.
- R10: Function B8h keeps rx_ready_o low for RECALL_CYCLES cycles, then loads bytes 2 to 4 from the shadow. Slots return 0 while it runs and 1 afterwards.
- R11: Function 44h runs for CONV_BASE shifted left by the resolution field (byte 4 bits 6:5) cycles. Slots return 0 until the cycle after completion. Bytes 0 and 1 then hold temp_i with the low (3 minus field) bits cleared.
- R12: Function B4h answers each slot with ext_pwr_i (1 external supply, 0 bus powered).
- R13: Each slot request not cut off by a bus reset gets slot_vld_o in the next cycle, with no other slot_vld_o. Slots outside the states above return 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset seen by the front end, one-cycle strobe |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Byte can be taken; low during copy or recall |
| slot_req_i | input | 1 | Master read-slot request, one cycle per bit |
| slot_vld_o | output | 1 | Slot answer valid |
| slot_bit_o | output | 1 | Bit returned for the slot |
| temp_i | input | 16 | Raw two's complement temperature from the sensor |
| ext_pwr_i | input | 1 | Device has an external supply |

## Verification
A bus reset and an accepted byte can land on the same edge. The bench raises both in one cycle, with a match-address code on the byte lines. It then checks that the scratchpad read that follows works, which it would not if the match code had opened an identity comparison. An operation can also end in the same cycle a status slot is sampled. The bench places a slot exactly on the last busy edge of a conversion and expects 0 there and 1 on the next slot.

// File: rtl/ow_cmd_pkg.sv
package ow_cmd_pkg;
  localparam logic [7:0] CMD_READ_ID   = 8'h33;
  localparam logic [7:0] CMD_MATCH_ID  = 8'h55;
  localparam logic [7:0] CMD_SKIP_ID   = 8'hCC;
  localparam logic [7:0] CMD_CONVERT   = 8'h44;
  localparam logic [7:0] CMD_WRITE_SP  = 8'h4E;
  localparam logic [7:0] CMD_READ_SP   = 8'hBE;
  localparam logic [7:0] CMD_COPY_NV   = 8'h48;
  localparam logic [7:0] CMD_RECALL_NV = 8'hB8;
  localparam logic [7:0] CMD_POWER     = 8'hB4;

  localparam logic [7:0] FAMILY_CODE = 8'h28;
  localparam logic [7:0] FIX_B5 = 8'hFF;
  localparam logic [7:0] FIX_B6 = 8'h0C;
  localparam logic [7:0] FIX_B7 = 8'h10;

  localparam int OP_CONV   = 0;
  localparam int OP_COPY   = 1;
  localparam int OP_RECALL = 2;
  localparam int N_OPS     = 3;

  typedef enum logic [3:0] {
    ST_WAIT, ST_ROM, ST_MATCH, ST_SEND_ID, ST_FUNC,
    ST_WRITE, ST_SEND_SP, ST_STATUS, ST_POWER
  } state_e;

  // reflected form of x^8+x^5+x^4+1, LSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [63:0] build_id(input logic [47:0] serial);
    logic [55:0] body;
    logic [7:0]  c;
    body = {serial, FAMILY_CODE};
    c = '0;
    for (int b = 0; b < 7; b++) c = crc8_step(c, body[b*8 +: 8]);
    return {c, body};
  endfunction
endpackage

// File: rtl/ow_busy_timer.sv
module ow_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !start_i;
endmodule

// File: rtl/ow_tx_ser.sv
module ow_tx_ser #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [IDX_W-1:0] nbytes_i,
  input  logic             slot_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       bit_o,
  output logic             done_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [2:0]       bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      bit_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      bit_q    <= '0;
      last_q   <= nbytes_i - 1'b1;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (slot_i && active_q) begin
      if (bit_q == 3'd7) begin
        bit_q <= '0;
        if (idx_q == last_q) active_q <= 1'b0;
        else                 idx_q    <= idx_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign bit_o  = bit_q;
  assign done_o = slot_i && active_q && !abort_i && (bit_q == 3'd7) && (idx_q == last_q);
endmodule

// File: rtl/ow_sp_store.sv
module ow_sp_store
  import ow_cmd_pkg::*;
#(
  parameter logic [7:0]  TH_INIT   = 8'h4B,
  parameter logic [7:0]  TL_INIT   = 8'h46,
  parameter logic [7:0]  CFG_INIT  = 8'h7F,
  parameter logic [15:0] TEMP_INIT = 16'h0550,
  parameter int          SP_BYTES  = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [7:0]  wr_data_i,
  input  logic        temp_ld_i,
  input  logic [15:0] temp_i,
  input  logic        copy_i,
  input  logic        recall_i,
  input  logic [3:0]  rd_idx_i,
  output logic [7:0]  rd_byte_o,
  output logic [1:0]  res_o
);
  localparam int CRC_IDX = SP_BYTES - 1;

  logic [15:0] temp_q;
  logic [7:0]  th_q, tl_q, nv_th_q, nv_tl_q;
  logic [1:0]  res_q, nv_res_q;
  logic [1:0]  drop;
  logic [7:0]  sp [SP_BYTES];
  logic [7:0]  crc;

  assign drop = 2'd3 - res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q   <= TEMP_INIT;
      th_q     <= TH_INIT;
      tl_q     <= TL_INIT;
      res_q    <= CFG_INIT[6:5];
      nv_th_q  <= TH_INIT;
      nv_tl_q  <= TL_INIT;
      nv_res_q <= CFG_INIT[6:5];
    end else begin
      if (temp_ld_i) temp_q <= temp_i & (16'hFFFF << drop);
      if (recall_i) begin
        th_q  <= nv_th_q;
        tl_q  <= nv_tl_q;
        res_q <= nv_res_q;
      end else if (wr_en_i) begin
        case (wr_sel_i)
          2'd0:    th_q  <= wr_data_i;
          2'd1:    tl_q  <= wr_data_i;
          default: res_q <= wr_data_i[6:5];
        endcase
      end
      if (copy_i) begin
        nv_th_q  <= th_q;
        nv_tl_q  <= tl_q;
        nv_res_q <= res_q;
      end
    end
  end

  always_comb begin
    sp[0] = temp_q[7:0];
    sp[1] = temp_q[15:8];
    sp[2] = th_q;
    sp[3] = tl_q;
    sp[4] = {1'b0, res_q, 5'h1F};
    sp[5] = FIX_B5;
    sp[6] = FIX_B6;
    sp[7] = FIX_B7;
    crc = '0;
    for (int i = 0; i < CRC_IDX; i++) crc = crc8_step(crc, sp[i]);
    sp[CRC_IDX] = crc;
  end

  always_comb begin
    rd_byte_o = 8'hFF;
    if (rd_idx_i < 4'(SP_BYTES)) rd_byte_o = sp[rd_idx_i];
  end

  assign res_o = res_q;
endmodule

// File: rtl/ow_cmd_ctrl.sv
module ow_cmd_ctrl
  import ow_cmd_pkg::*;
#(
  parameter logic [47:0] SERIAL        = 48'h00A1_B2C3_D4E5,
  parameter logic [7:0]  TH_INIT       = 8'h4B,
  parameter logic [7:0]  TL_INIT       = 8'h46,
  parameter logic [7:0]  CFG_INIT      = 8'h7F,
  parameter int          CNT_W         = 16,
  parameter int          CONV_BASE     = 100,
  parameter int          COPY_CYCLES   = 200,
  parameter int          RECALL_CYCLES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_rst_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  input  logic        slot_req_i,
  output logic        slot_vld_o,
  output logic        slot_bit_o,
  input  logic [15:0] temp_i,
  input  logic        ext_pwr_i
);
  localparam logic [63:0] DEV_ID   = build_id(SERIAL);
  localparam int          ID_BYTES = 8;
  localparam int          SP_BYTES = 9;
  localparam int          IDX_W    = 4;

  state_e           state_q, state_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [1:0]       sel_q, sel_d;
  logic             rx_fire, slot_go, slot_bit_d;
  logic [N_OPS-1:0] op_start, op_busy, op_done;
  logic [CNT_W-1:0] op_len [N_OPS];
  logic             tx_start, tx_slot, tx_done;
  logic [IDX_W-1:0] tx_nbytes, tx_idx;
  logic [2:0]       tx_bit;
  logic             wr_en;
  logic [7:0]       sp_byte, id_byte, match_byte;
  logic [1:0]       sp_res;

  assign rx_ready_o = ~(op_busy[OP_COPY] | op_busy[OP_RECALL]);
  assign rx_fire    = rx_valid_i & rx_ready_o & ~bus_rst_i;
  assign slot_go    = slot_req_i & ~bus_rst_i;
  assign tx_slot    = slot_go & ((state_q == ST_SEND_ID) | (state_q == ST_SEND_SP));
  assign match_byte = DEV_ID[{cnt_q, 3'b000} +: 8];
  assign id_byte    = DEV_ID[{tx_idx[2:0], 3'b000} +: 8];

  assign op_len[OP_CONV]   = CNT_W'(CONV_BASE) << sp_res;
  assign op_len[OP_COPY]   = CNT_W'(COPY_CYCLES);
  assign op_len[OP_RECALL] = CNT_W'(RECALL_CYCLES);

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    ow_busy_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (op_start[g]),
      .len_i   (op_len[g]),
      .busy_o  (op_busy[g]),
      .done_o  (op_done[g])
    );
  end

  ow_tx_ser #(.IDX_W(IDX_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_start),
    .abort_i  (bus_rst_i | rx_fire),
    .nbytes_i (tx_nbytes),
    .slot_i   (tx_slot),
    .idx_o    (tx_idx),
    .bit_o    (tx_bit),
    .done_o   (tx_done)
  );

  ow_sp_store #(
    .TH_INIT  (TH_INIT),
    .TL_INIT  (TL_INIT),
    .CFG_INIT (CFG_INIT),
    .SP_BYTES (SP_BYTES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (cnt_q[1:0]),
    .wr_data_i (rx_data_i),
    .temp_ld_i (op_done[OP_CONV]),
    .temp_i    (temp_i),
    .copy_i    (op_done[OP_COPY]),
    .recall_i  (op_done[OP_RECALL]),
    .rd_idx_i  (tx_idx),
    .rd_byte_o (sp_byte),
    .res_o     (sp_res)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sel_d     = sel_q;
    op_start  = '0;
    tx_start  = 1'b0;
    tx_nbytes = IDX_W'(ID_BYTES);
    wr_en     = 1'b0;
    if (bus_rst_i) begin
      state_d = ST_ROM;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_ROM: if (rx_fire) begin
          case (rx_data_i)
            CMD_READ_ID:  begin state_d = ST_SEND_ID; tx_start = 1'b1; end
            CMD_MATCH_ID: begin state_d = ST_MATCH; cnt_d = '0; end
            CMD_SKIP_ID:  state_d = ST_FUNC;
            default:      state_d = ST_WAIT;
          endcase
        end
        ST_MATCH: if (rx_fire) begin
          if (rx_data_i != match_byte) state_d = ST_WAIT;
          else if (cnt_q == 3'd7)      state_d = ST_FUNC;
          else                         cnt_d   = cnt_q + 1'b1;
        end
        ST_SEND_ID: begin
          if (rx_fire)      state_d = ST_WAIT;
          else if (tx_done) state_d = ST_FUNC;
        end
        ST_FUNC: if (rx_fire) begin
          case (rx_data_i)
            CMD_CONVERT: begin
              op_start[OP_CONV] = 1'b1; sel_d = 2'(OP_CONV); state_d = ST_STATUS;
            end
            CMD_COPY_NV: begin
              op_start[OP_COPY] = 1'b1; sel_d = 2'(OP_COPY); state_d = ST_STATUS;
            end
            CMD_RECALL_NV: begin
              op_start[OP_RECALL] = 1'b1; sel_d = 2'(OP_RECALL); state_d = ST_STATUS;
            end
            CMD_WRITE_SP: begin state_d = ST_WRITE; cnt_d = '0; end
            CMD_READ_SP: begin
              state_d = ST_SEND_SP; tx_start = 1'b1; tx_nbytes = IDX_W'(SP_BYTES);
            end
            CMD_POWER: state_d = ST_POWER;
            default:   state_d = ST_WAIT;
          endcase
        end
        ST_WRITE: if (rx_fire) begin
          wr_en = 1'b1;
          if (cnt_q == 3'd2) state_d = ST_WAIT;
          else               cnt_d   = cnt_q + 1'b1;
        end
        ST_SEND_SP: if (rx_fire || tx_done) state_d = ST_WAIT;
        ST_STATUS, ST_POWER: if (rx_fire) state_d = ST_WAIT;
        default: state_d = ST_WAIT;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_SEND_ID: slot_bit_d = id_byte[tx_bit];
      ST_SEND_SP: slot_bit_d = sp_byte[tx_bit];
      ST_STATUS:  slot_bit_d = ~op_busy[sel_q];
      ST_POWER:   slot_bit_d = ext_pwr_i;
      default:    slot_bit_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT;
      cnt_q      <= '0;
      sel_q      <= '0;
      slot_vld_o <= 1'b0;
      slot_bit_o <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      sel_q      <= sel_d;
      slot_vld_o <= slot_go;
      slot_bit_o <= slot_go ? slot_bit_d : 1'b1;
    end
  end
endmodule

// File: rtl/ow_cmd_ctrl_chk.sv
module ow_cmd_ctrl_chk
  import ow_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rst_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       rx_ready_o,
  input logic       slot_req_i,
  input logic       slot_vld_o,
  input logic       slot_bit_o,
  input logic       ext_pwr_i,
  input state_e     state_q
);
  a_r13_slot_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_req_i && !bus_rst_i) |=> slot_vld_o);

  a_r13_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_req_i && !bus_rst_i) |=> !slot_vld_o);

  a_r2_bus_rst_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (state_q == ST_ROM));

  a_r2_wait_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !bus_rst_i) |=> (state_q == ST_WAIT));

  a_r2_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && slot_req_i && !bus_rst_i) |=> slot_bit_o);

  a_r12_power_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWER && slot_req_i && !bus_rst_i) |=> (slot_bit_o == $past(ext_pwr_i)));

  a_r9_copy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FUNC && rx_valid_i && rx_ready_o && !bus_rst_i && rx_data_i == CMD_COPY_NV)
      |=> !rx_ready_o);

  a_r10_recall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FUNC && rx_valid_i && rx_ready_o && !bus_rst_i && rx_data_i == CMD_RECALL_NV)
      |=> !rx_ready_o);
endmodule

bind ow_cmd_ctrl ow_cmd_ctrl_chk u_chk (.*);

// File: tb/ow_cmd_ctrl_tb.sv
module ow_cmd_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] SER        = 48'hB1C2_D3E4_F506;
  localparam logic [7:0]  TH0 = 8'h4B, TL0 = 8'h46, CFG0 = 8'h7F;
  localparam int          CB = 20, CPY = 30, RCL = 5;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0, rx_valid = 1'b0, slot_req = 1'b0, ext_pwr = 1'b1;
  logic [7:0]  rx_data = '0;
  logic [15:0] temp = '0;
  logic rx_ready, slot_vld, slot_bit;

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  logic [15:0] m_temp;
  logic [7:0]  m_th, m_tl, nv_th, nv_tl;
  logic [1:0]  m_res, nv_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_cmd_ctrl #(
    .SERIAL(SER), .TH_INIT(TH0), .TL_INIT(TL0), .CFG_INIT(CFG0),
    .CNT_W(16), .CONV_BASE(CB), .COPY_CYCLES(CPY), .RECALL_CYCLES(RCL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .slot_req_i(slot_req), .slot_vld_o(slot_vld), .slot_bit_o(slot_bit),
    .temp_i(temp), .ext_pwr_i(ext_pwr)
  );

  function automatic logic [7:0] b_crc(input logic [7:0] c0, input logic [7:0] d);
    logic [7:0] c = c0;
    for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) begin c[7] = ~c[7]; c[3] = ~c[3]; c[2] = ~c[2]; end
    end
    return c;
  endfunction

  function automatic logic [7:0] id_byte(input int i);
    logic [55:0] body = {SER, 8'h28};
    logic [7:0]  c = 8'h00;
    if (i < 7) return body[i*8 +: 8];
    for (int k = 0; k < 7; k++) c = b_crc(c, body[k*8 +: 8]);
    return c;
  endfunction

  function automatic logic [7:0] model_byte(input int i);
    logic [7:0] c = 8'h00;
    case (i)
      0: return m_temp[7:0];
      1: return m_temp[15:8];
      2: return m_th;
      3: return m_tl;
      4: return {1'b0, m_res, 5'b11111};
      5: return 8'hFF;
      6: return 8'h0C;
      7: return 8'h10;
      default: begin
        for (int k = 0; k < 8; k++) c = b_crc(c, model_byte(k));
        return c;
      end
    endcase
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic pulse_bus_rst();
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_bit(output logic b, output logic v);
    slot_req = 1'b1;
    @(negedge clk);
    slot_req = 1'b0;
    b = slot_bit;
    v = slot_vld;
  endtask

  task automatic read_byte(output logic [7:0] d);
    logic b, v;
    for (int i = 0; i < 8; i++) begin
      read_bit(b, v);
      d[i] = b;
    end
  endtask

  task automatic read_sp_all(input string req);
    logic [7:0] d;
    pulse_bus_rst();
    send(8'hCC);
    send(8'hBE);
    for (int i = 0; i < 9; i++) begin
      read_byte(d);
      chk((i == 8) ? "R6 scratchpad check byte" : req, d, model_byte(i));
    end
  endtask

  task automatic write_sp(input logic [7:0] th, input logic [7:0] tl, input logic [7:0] cfg);
    pulse_bus_rst();
    send(8'hCC);
    send(8'h4E);
    send(th);
    send(tl);
    send(cfg);
    m_th = th; m_tl = tl; m_res = cfg[6:5];
  endtask

  task automatic wait_ready();
    while (!rx_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] d;
    logic b, v;
    int n;
    void'($urandom(32'd1855));
    m_temp = 16'h0550; m_th = TH0; m_tl = TL0; m_res = CFG0[6:5];
    nv_th = TH0; nv_tl = TL0; nv_res = CFG0[6:5];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 power-on contents
    chk("R1 ready after reset", rx_ready, 1'b1);
    read_sp_all("R1 power-on scratchpad");

    // R3 identity read, then a function command is accepted
    pulse_bus_rst();
    send(8'h33);
    for (int i = 0; i < 8; i++) begin
      read_byte(d);
      chk((i == 7) ? "R6 identity check byte" : "R3 identity byte", d, id_byte(i));
    end
    send(8'hBE);
    read_byte(d);
    chk("R3 function after identity", d, model_byte(0));

    // R4 exact match
    pulse_bus_rst();
    send(8'h55);
    for (int i = 0; i < 8; i++) send(id_byte(i));
    send(8'hBE);
    read_byte(d);
    chk("R4 match accepted", d, model_byte(0));

    // R4 mismatch in byte 3
    pulse_bus_rst();
    send(8'h55);
    for (int i = 0; i < 8; i++) send((i == 3) ? (id_byte(i) ^ 8'h01) : id_byte(i));
    send(8'hBE);
    read_byte(d);
    chk("R4 mismatch ignored", d, 8'hFF);

    // R2 function without addressing, unknown addressing code
    pulse_bus_rst();
    send(8'hBE);
    read_byte(d);
    chk("R2 function before addressing", d, 8'hFF);
    pulse_bus_rst();
    send(8'hA5);
    send(8'hCC);
    send(8'hBE);
    read_byte(d);
    chk("R2 unknown addressing code", d, 8'hFF);

    // R2 bus reset and byte in the same cycle
    pulse_bus_rst();
    bus_rst = 1'b1; rx_valid = 1'b1; rx_data = 8'h55;
    @(negedge clk);
    bus_rst = 1'b0; rx_valid = 1'b0;
    send(8'hCC);
    send(8'hBE);
    read_byte(d);
    chk("R2 byte dropped on bus reset", d, model_byte(0));

    // R5 skip then slot outside a read state (R13)
    pulse_bus_rst();
    send(8'hCC);
    read_bit(b, v);
    chk("R13 idle slot valid", v, 1'b1);
    chk("R5 R13 idle slot released", b, 1'b1);

    // R7 random writes with read-back
    for (int k = 0; k < 5; k++) begin
      write_sp(8'($urandom), 8'($urandom), 8'($urandom));
      read_sp_all("R7 written scratchpad");
    end

    // R7 write cut short after the first byte
    pulse_bus_rst();
    send(8'hCC);
    send(8'h4E);
    d = 8'($urandom);
    send(d);
    m_th = d;
    pulse_bus_rst();
    read_sp_all("R7 partial write");

    // R8 read cut short, and released slots after the last byte
    pulse_bus_rst();
    send(8'hCC);
    send(8'hBE);
    read_byte(d);
    read_byte(d);
    chk("R8 second byte", d, model_byte(1));
    pulse_bus_rst();
    send(8'hCC);
    send(8'hBE);
    for (int i = 0; i < 9; i++) read_byte(d);
    read_bit(b, v);
    chk("R8 slot after last byte", b, 1'b1);

    // R9 copy length and status
    write_sp(8'hA1, 8'h5C, 8'h20);
    pulse_bus_rst();
    send(8'hCC);
    send(8'h48);
    n = 0;
    while (!rx_ready) begin n++; @(negedge clk); end
    chk("R9 copy busy cycles", n, CPY);
    nv_th = m_th; nv_tl = m_tl; nv_res = m_res;
    pulse_bus_rst();
    send(8'hCC);
    send(8'h48);
    read_bit(b, v);
    chk("R9 copy status busy", b, 1'b0);
    wait_ready();
    read_bit(b, v);
    chk("R9 copy status done", b, 1'b1);

    // R10 recall restores the shadow
    write_sp(8'($urandom), 8'($urandom), 8'($urandom));
    pulse_bus_rst();
    send(8'hCC);
    send(8'hB8);
    read_bit(b, v);
    chk("R10 recall status busy", b, 1'b0);
    n = 1;
    while (!rx_ready) begin n++; @(negedge clk); end
    chk("R10 recall busy cycles", n, RCL);
    read_bit(b, v);
    chk("R10 recall status done", b, 1'b1);
    m_th = nv_th; m_tl = nv_tl; m_res = nv_res;
    read_sp_all("R10 recalled scratchpad");

    // R11 conversion per resolution, slot on the completing edge
    for (int r = 0; r < 4; r++) begin
      int len;
      write_sp(8'($urandom), 8'($urandom), {1'b0, 2'(r), 5'b00000});
      temp = 16'($urandom);
      len = CB << r;
      pulse_bus_rst();
      send(8'hCC);
      send(8'h44);
      repeat (len - 1) @(negedge clk);
      read_bit(b, v);
      chk("R11 busy on final edge", b, 1'b0);
      read_bit(b, v);
      chk("R11 done after final edge", b, 1'b1);
      m_temp = temp & (16'hFFFF << (3 - r));
      read_sp_all("R11 converted temperature");
    end

    // R12 power mode
    pulse_bus_rst();
    send(8'hCC);
    send(8'hB4);
    ext_pwr = 1'b1;
    read_bit(b, v);
    chk("R12 external supply", b, 1'b1);
    ext_pwr = 1'b0;
    read_bit(b, v);
    chk("R12 bus powered", b, 1'b0);
    ext_pwr = 1'b1;

    repeat (4) @(negedge clk);
    report();
  end
endmodule